// File: doc/BRIEF.md
# EISA Bus Master/Slave Pin Sequencer

This block owns the EISA-side pins of a bridge and switches them between a master role and a slave role. It runs on a clock at twice the bus-clock rate. An internal phase bit, visible as `bclk_o`, marks which clock edges are rising and which are falling bus-clock edges, so that events can be placed on half-bus-clock boundaries.

In the master role the block accepts one cycle request at a time, and only on a rising bus edge. It then drives START for one bus clock and presents the latchable address with the upper byte inverted. On I/O cycles it floats that upper byte. It drives the byte enables, samples the slave's burst reply when START ends, and, for a slave without 32-bit support, releases the byte enables so that an external controller can drive them. It also drives the bus lock while the upstream side asks for locked cycles. In the slave role it advertises burst support, keeps its master-only pins floated, and captures the address and byte enables that another master presents. A lock asserted by another bus device is forwarded upstream.

Top module: `eisa_pin_seq`

## Requirements
- R1: While `rst_ni` is low, every pin output enable is low and `start_n_o` is high. After reset, in the master role and while idle, `be_oe_o` is high and `busy_o` is low.
- R2: A request is accepted on a clock edge where `bclk_o` is low before the edge, which is a rising bus edge. `start_n_o` is then low for exactly two clocks (one bus clock). Two clocks of command phase follow, then one clock of done phase, and `busy_o` falls on the sixth clock.
- R3: While `busy_o` is high, `la_lo_oe_o` is high and `la_o` equals {~addr[31:24], addr[23:2]}, where `req_addr_i` carries bits 31:2 of the address.
- R4: `la_hi_oe_o` is high during a cycle only when `req_mem_i`=1 (memory). For `req_mem_i`=0 (I/O) it stays low while bits 23:2 are still driven.
- R5: `burst_ok_o` takes the inverse of the active-low `slburst_n_i` as sampled on the rising bus edge that ends START. It is visible from the first command half and holds until the next request.
- R6: When `req_match_i`=1 (matched 32-bit slave), `be_oe_o` stays high for the whole cycle and `be_o` shows the requested byte enables.
- R7: When `req_match_i`=0, `be_oe_o` falls three half bus clocks after START asserts (the fourth clock of the cycle). It stays low through the done phase and is high again once idle. `mm_be_o` then holds the `be_i` value sampled at the end of the done phase.
- R8: In the slave role, `slburst_oe_o`=1 and `slburst_n_o`=0, while `start_oe_o`, `la_lo_oe_o`, `la_hi_oe_o` and `be_oe_o` are 0.
- R9: In the slave role, `slv_addr_o` and `slv_be_o` capture `la_i` and `be_i` on the first rising bus edge at which `start_n_i` is low.
- R10: In the master role, one clock after `req_lock_i` rises, `lock_oe_o`=1 and `lock_n_o`=0. Both are released one clock after `req_lock_i` falls.
- R11: One clock after another device pulls `lock_n_i` low while this block is not driving the lock, `up_lock_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bus-clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| role_master_i | input | 1 | 1 = master role, 0 = slave role |
| req_i | input | 1 | Master cycle request |
| req_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_match_i | input | 1 | 1 = target supports 32-bit transfers |
| req_lock_i | input | 1 | Upstream is running locked cycles |
| req_addr_i | input | 30 | Address bits 31:2 |
| req_be_i | input | 4 | Requested byte enables |
| busy_o | output | 1 | Master cycle in progress |
| bclk_o | output | 1 | Bus-clock phase |
| start_n_o | output | 1 | START pin value, active low |
| start_oe_o | output | 1 | START output enable |
| start_n_i | input | 1 | START from another master |
| la_o | output | 30 | Latchable address pin values |
| la_hi_oe_o | output | 1 | Output enable, upper address byte |
| la_lo_oe_o | output | 1 | Output enable, address bits 23:2 |
| la_i | input | 30 | Latchable address pin inputs |
| be_o | output | 4 | Byte-enable pin values |
| be_oe_o | output | 1 | Byte-enable output enable |
| be_i | input | 4 | Byte-enable pin inputs |
| slburst_n_o | output | 1 | Burst-support pin value, active low |
| slburst_oe_o | output | 1 | Burst-support output enable |
| slburst_n_i | input | 1 | Burst-support reply from slave |
| burst_ok_o | output | 1 | Target accepted burst for this cycle |
| mm_be_o | output | 4 | Byte enables observed during a mismatched cycle |
| lock_n_o | output | 1 | Lock pin value, active low |
| lock_oe_o | output | 1 | Lock output enable |
| lock_n_i | input | 1 | Lock pin input |
| up_lock_o | output | 1 | Lock forwarded upstream |
| slv_addr_o | output | 30 | Address captured as slave |
| slv_be_o | output | 4 | Byte enables captured as slave |

## Verification
A sequencer state that advances early or late shows within one half bus clock, as a START pulse that is not two clocks long or a shifted fall of `busy_o`. A wrong mismatch or I/O flag shows as a byte-enable or upper-address output enable with the wrong value in a specific half of the cycle. The bench compares every pin and output enable on every half bus clock of each cycle. A mis-sampled burst reply or lock state appears on `burst_ok_o` or the lock pins one clock after the event that should have set it.

// File: rtl/eisa_seq_pkg.sv
package eisa_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_CMD   = 2'd2,
    ST_DONE  = 2'd3
  } mst_state_e;
endpackage

// File: rtl/eisa_phase_gen.sv
module eisa_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_ev_o,
  output logic bclk_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // ph_q high: the coming edge is a rising bus-clock edge
  assign rise_ev_o = ph_q;
  assign bclk_o    = ~ph_q;
endmodule

// File: rtl/eisa_mst_seq.sv
module eisa_mst_seq
  import eisa_seq_pkg::*;
#(
  parameter int LA_W = 30,
  parameter int BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_ev_i,
  input  logic            en_i,
  input  logic            req_i,
  input  logic            req_mem_i,
  input  logic            req_match_i,
  input  logic [LA_W-1:0] req_addr_i,
  input  logic [BE_W-1:0] req_be_i,
  input  logic            slburst_n_i,
  input  logic [BE_W-1:0] be_i,
  output mst_state_e      state_o,
  output logic [LA_W-1:0] addr_o,
  output logic [BE_W-1:0] be_o,
  output logic            mem_o,
  output logic            be_rel_o,
  output logic            burst_ok_o,
  output logic [BE_W-1:0] mm_be_o
);
  mst_state_e state_q;
  logic       match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_o     <= '0;
      be_o       <= '0;
      mem_o      <= 1'b0;
      match_q    <= 1'b1;
      be_rel_o   <= 1'b0;
      burst_ok_o <= 1'b0;
      mm_be_o    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (en_i && rise_ev_i && req_i) begin
          state_q    <= ST_START;
          addr_o     <= req_addr_i;
          be_o       <= req_be_i;
          mem_o      <= req_mem_i;
          match_q    <= req_match_i;
          burst_ok_o <= 1'b0;
        end
        ST_START: if (rise_ev_i) begin
          state_q    <= ST_CMD;
          burst_ok_o <= ~slburst_n_i;
        end
        ST_CMD: begin
          if (rise_ev_i)     state_q  <= ST_DONE;
          else if (!match_q) be_rel_o <= 1'b1; // 1.5 bus clocks after START
        end
        default: begin
          state_q  <= ST_IDLE;
          be_rel_o <= 1'b0;
          if (!match_q) mm_be_o <= be_i;
        end
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/eisa_slv_latch.sv
module eisa_slv_latch #(
  parameter int LA_W = 30,
  parameter int BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rise_ev_i,
  input  logic            start_n_i,
  input  logic [LA_W-1:0] la_i,
  input  logic [BE_W-1:0] be_i,
  output logic [LA_W-1:0] addr_o,
  output logic [BE_W-1:0] be_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      addr_o <= '0;
      be_o   <= '0;
    end else if (rise_ev_i) begin
      if (start_n_i) begin
        seen_q <= 1'b0;
      end else if (en_i && !seen_q) begin
        seen_q <= 1'b1;
        addr_o <= la_i;
        be_o   <= be_i;
      end
    end
  end
endmodule

// File: rtl/eisa_lock_fwd.sv
module eisa_lock_fwd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_req_i,
  input  logic lock_n_i,
  output logic lock_act_o,
  output logic up_lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_act_o <= 1'b0;
      up_lock_o  <= 1'b0;
    end else begin
      lock_act_o <= lock_req_i;
      up_lock_o  <= ~lock_n_i & ~lock_act_o;
    end
  end
endmodule

// File: rtl/eisa_pin_seq.sv
module eisa_pin_seq
  import eisa_seq_pkg::*;
#(
  parameter int LA_W = 30,
  parameter int HI_W = 8,
  parameter int BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            role_master_i,
  input  logic            req_i,
  input  logic            req_mem_i,
  input  logic            req_match_i,
  input  logic            req_lock_i,
  input  logic [LA_W-1:0] req_addr_i,
  input  logic [BE_W-1:0] req_be_i,
  output logic            busy_o,
  output logic            bclk_o,
  output logic            start_n_o,
  output logic            start_oe_o,
  input  logic            start_n_i,
  output logic [LA_W-1:0] la_o,
  output logic            la_hi_oe_o,
  output logic            la_lo_oe_o,
  input  logic [LA_W-1:0] la_i,
  output logic [BE_W-1:0] be_o,
  output logic            be_oe_o,
  input  logic [BE_W-1:0] be_i,
  output logic            slburst_n_o,
  output logic            slburst_oe_o,
  input  logic            slburst_n_i,
  output logic            burst_ok_o,
  output logic [BE_W-1:0] mm_be_o,
  output logic            lock_n_o,
  output logic            lock_oe_o,
  input  logic            lock_n_i,
  output logic            up_lock_o,
  output logic [LA_W-1:0] slv_addr_o,
  output logic [BE_W-1:0] slv_be_o
);
  localparam int LO_W = LA_W - HI_W;

  logic            run_q, role_q;
  logic            en_m, en_s, rise_ev;
  mst_state_e      state;
  logic [LA_W-1:0] addr_q;
  logic            mem_q, be_rel, lock_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      role_q <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      role_q <= role_master_i;
    end
  end

  assign en_m = run_q & role_q;
  assign en_s = run_q & ~role_q;

  eisa_phase_gen i_phase (
    .clk_i, .rst_ni, .rise_ev_o(rise_ev), .bclk_o
  );

  eisa_mst_seq #(.LA_W(LA_W), .BE_W(BE_W)) i_mst (
    .clk_i, .rst_ni,
    .rise_ev_i  (rise_ev),
    .en_i       (en_m),
    .req_i, .req_mem_i, .req_match_i, .req_addr_i, .req_be_i,
    .slburst_n_i, .be_i,
    .state_o    (state),
    .addr_o     (addr_q),
    .be_o,
    .mem_o      (mem_q),
    .be_rel_o   (be_rel),
    .burst_ok_o, .mm_be_o
  );

  eisa_slv_latch #(.LA_W(LA_W), .BE_W(BE_W)) i_slv (
    .clk_i, .rst_ni,
    .en_i      (en_s),
    .rise_ev_i (rise_ev),
    .start_n_i, .la_i, .be_i,
    .addr_o    (slv_addr_o),
    .be_o      (slv_be_o)
  );

  eisa_lock_fwd i_lock (
    .clk_i, .rst_ni,
    .lock_req_i (en_m & req_lock_i),
    .lock_n_i,
    .lock_act_o (lock_act),
    .up_lock_o
  );

  // upper byte driven inverted, lower bits straight
  for (genvar i = 0; i < LA_W; i++) begin : g_la
    if (i >= LO_W) begin : g_hi
      assign la_o[i] = ~addr_q[i];
    end else begin : g_lo
      assign la_o[i] = addr_q[i];
    end
  end

  assign busy_o       = (state != ST_IDLE);
  assign start_n_o    = (state != ST_START);
  assign start_oe_o   = en_m;
  assign la_lo_oe_o   = en_m & busy_o;
  assign la_hi_oe_o   = en_m & busy_o & mem_q;
  assign be_oe_o      = en_m & ~be_rel;
  assign slburst_oe_o = en_s;
  assign slburst_n_o  = ~en_s;
  assign lock_oe_o    = lock_act;
  assign lock_n_o     = ~lock_act;
endmodule

// File: rtl/eisa_pin_seq_chk.sv
module eisa_pin_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic start_n_o,
  input logic start_oe_o,
  input logic la_hi_oe_o,
  input logic la_lo_oe_o,
  input logic be_oe_o,
  input logic slburst_n_o,
  input logic slburst_oe_o,
  input logic lock_n_o,
  input logic lock_oe_o,
  input logic up_lock_o
);
  // R2
  start_two_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_n_o) |=> !start_n_o);

  // R4
  hi_needs_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    la_hi_oe_o |-> la_lo_oe_o);

  // R6
  be_driven_in_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_n_o |-> be_oe_o);

  // R7
  be_release_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_oe_o && !be_oe_o) |-> busy_o);

  // R8
  slave_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slburst_oe_o |-> (!slburst_n_o && !start_oe_o && !la_lo_oe_o));

  // R10
  lock_drive_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_oe_o |-> !lock_n_o);

  // R11
  up_lock_foreign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_lock_o |-> !$past(lock_oe_o));
endmodule

bind eisa_pin_seq eisa_pin_seq_chk i_chk (
  .clk_i, .rst_ni, .busy_o, .start_n_o, .start_oe_o, .la_hi_oe_o,
  .la_lo_oe_o, .be_oe_o, .slburst_n_o, .slburst_oe_o, .lock_n_o,
  .lock_oe_o, .up_lock_o
);

// File: tb/test_eisa_pin_seq.sv
module test_eisa_pin_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        role_master_i = 1'b1;
  logic        req_i = 1'b0, req_mem_i = 1'b0, req_match_i = 1'b1, req_lock_i = 1'b0;
  logic [29:0] req_addr_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        busy_o, bclk_o, start_n_o, start_oe_o;
  logic        start_n_i = 1'b1;
  logic [29:0] la_o, la_i = '0;
  logic        la_hi_oe_o, la_lo_oe_o;
  logic [3:0]  be_o, be_i = '0;
  logic        be_oe_o, slburst_n_o, slburst_oe_o;
  logic        slburst_n_i = 1'b1;
  logic        burst_ok_o;
  logic [3:0]  mm_be_o;
  logic        lock_n_o, lock_oe_o, up_lock_o;
  logic        lock_n_i = 1'b1;
  logic [29:0] slv_addr_o;
  logic [3:0]  slv_be_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  eisa_pin_seq i_eisa_pin_seq (.*);

  typedef struct {
    logic        busy, start_n, lo_oe, hi_oe, be_oe, lock_oe;
    logic [29:0] la;
    logic [3:0]  be;
    logic        burst_chk, burst;
    logic        mm_chk;
    logic [3:0]  mm;
  } exp_t;

  exp_t q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per half bus clock
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2 busy", 32'(busy_o), 32'(e.busy));
        chk("R2 start_n", 32'(start_n_o), 32'(e.start_n));
        chk("R3 la_lo_oe", 32'(la_lo_oe_o), 32'(e.lo_oe));
        chk("R4 la_hi_oe", 32'(la_hi_oe_o), 32'(e.hi_oe));
        chk("R7 be_oe", 32'(be_oe_o), 32'(e.be_oe));
        chk("R10 lock_oe", 32'(lock_oe_o), 32'(e.lock_oe));
        if (e.lo_oe) chk("R3 la", 32'(la_o), 32'(e.la));
        if (e.be_oe && e.busy) chk("R6 be", 32'(be_o), 32'(e.be));
        if (e.burst_chk) chk("R5 burst_ok", 32'(burst_ok_o), 32'(e.burst));
        if (e.mm_chk) chk("R7 mm_be", 32'(mm_be_o), 32'(e.mm));
      end
    end
  end

  task automatic run_cycle(logic mem, logic match, logic lock, logic [29:0] a,
                           logic [3:0] b, logic slb_n, logic [3:0] ext_be);
    @(negedge clk_i);
    req_mem_i = mem; req_match_i = match; req_lock_i = lock;
    req_addr_i = a; req_be_i = b; slburst_n_i = slb_n; be_i = ext_be;
    @(negedge clk_i);
    @(negedge clk_i);
    while (bclk_o !== 1'b0) @(negedge clk_i);
    req_i = 1'b1;
    @(posedge clk_i);
    #1 req_i = 1'b0;
    for (int j = 0; j < 6; j++) begin
      exp_t e;
      e.busy      = (j < 5);
      e.start_n   = (j >= 2);
      e.lo_oe     = (j < 5);
      e.hi_oe     = (j < 5) && mem;
      e.be_oe     = match || j < 3 || j == 5;
      e.lock_oe   = lock;
      e.la        = {~a[29:22], a[21:0]};
      e.be        = b;
      e.burst_chk = (j >= 2);
      e.burst     = ~slb_n;
      e.mm_chk    = (j == 5) && !match;
      e.mm        = ext_be;
      q.push_back(e);
    end
    while (q.size() > 0) @(negedge clk_i);
    if (lock) begin
      req_lock_i = 1'b0;
      @(negedge clk_i);
      chk("R10 lock released", 32'(lock_oe_o), 32'h0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #55;
    chk("R1 reset oe", {28'h0, la_lo_oe_o, be_oe_o, slburst_oe_o, lock_oe_o}, 32'h0);
    chk("R1 reset start", 32'(start_n_o), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 idle be_oe", 32'(be_oe_o), 32'h1);
    chk("R1 idle busy", 32'(busy_o), 32'h0);

    run_cycle(1'b1, 1'b1, 1'b0, 30'h2345_6789, 4'hF, 1'b0, 4'h0);
    run_cycle(1'b1, 1'b0, 1'b0, 30'h1ABC_DEF0, 4'h3, 1'b1, 4'h6);
    run_cycle(1'b0, 1'b1, 1'b0, 30'h00FF_1234, 4'h8, 1'b1, 4'h0);
    run_cycle(1'b1, 1'b1, 1'b1, 30'h3FC0_0001, 4'hC, 1'b0, 4'h0);
    run_cycle(1'b0, 1'b0, 1'b0, 30'h0123_4567, 4'h1, 1'b0, 4'h9);

    // foreign lock
    @(negedge clk_i);
    lock_n_i = 1'b0;
    @(negedge clk_i);
    chk("R11 up_lock set", 32'(up_lock_o), 32'h1);
    lock_n_i = 1'b1;
    @(negedge clk_i);
    chk("R11 up_lock clear", 32'(up_lock_o), 32'h0);

    // slave role
    role_master_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 slburst_oe", 32'(slburst_oe_o), 32'h1);
    chk("R8 slburst_n", 32'(slburst_n_o), 32'h0);
    chk("R8 master oes", {29'h0, start_oe_o, la_lo_oe_o, be_oe_o}, 32'h0);
    while (bclk_o !== 1'b0) @(negedge clk_i);
    la_i = 30'h1555_AAAA; be_i = 4'h5; start_n_i = 1'b0;
    @(negedge clk_i);
    chk("R9 slv_addr", 32'(slv_addr_o), 32'h1555_AAAA);
    chk("R9 slv_be", 32'(slv_be_o), 32'h5);
    la_i = 30'h0; be_i = 4'hA;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9 hold while start low", 32'(slv_addr_o), 32'h1555_AAAA);
    start_n_i = 1'b1;
    @(negedge clk_i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule